// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog that counts down a chosen timeout on a slow reference tick. Software picks one of twelve timeouts with a 4-bit interval code and must keep restarting the count. A restart only takes effect when the written control word carries the correct 12-bit key, so a stray or corrupted store cannot keep a hung system alive. When the count runs out, the block either drives a reset pulse toward the system reset logic or sets a pending flag that can raise an interrupt. A configuration field selects which of the two happens.

The register port is a plain single-cycle write strobe with a combinational read path. It takes every access in the cycle it is presented and never stalls, so there is no valid/ready handshake and no back-pressure. The reference tick is a one-clock pulse. The parameter `HALF_TICKS` sets how many tick pulses make half a second, so every timeout is a whole number of ticks.

Top module: `keyed_watchdog`

## Requirements
- R1: Registers sit at byte offsets 0x00 (interrupt enable, bit 0), 0x04 (status, bit 0 = pending), 0x10 (control), 0x14 (action, bits 1:0) and 0x18 (mode: bit 0 enable, bits 7:4 interval). Each reads back its stored fields with all other bits zero, and the control register always reads zero.
- R2: A control write restarts the countdown only when bit 0 is 1 and bits 12:1 equal 0xA57. Every other control write leaves the countdown unchanged.
- R3: Interval codes 0 to 11 give 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 half-seconds, and codes 12 to 15 give 32. Expiry occurs on the tick that completes that many half-seconds, counted as HALF_TICKS tick pulses each, after a restart.
- R4: With the mode enable at 0, the block never expires. A mode write that changes the enable or the interval reloads the countdown with the selected timeout.
- R5: With action value 1, an expiry drives `sys_rst` high for exactly 4 clock cycles and leaves the pending flag unchanged. The countdown is reloaded and does not advance during the pulse.
- R6: With action value 2, an expiry sets the pending flag. With action value 0 or 3, an expiry has no visible effect.
- R7: `irq` is high exactly when both the pending flag and the interrupt enable bit are 1.
- R8: Writing 1 to status bit 0 clears the pending flag, and writing 0 has no effect. If an expiry and a clearing write fall in the same cycle, the flag ends set.
- R9: A valid restart in the same cycle as the tick that would expire the count wins: no expiry occurs and the count is reloaded.
- R10: After reset, the watchdog is disabled, the interval code is 11 (16 s), the action is 1 (system reset), and the interrupt enable and pending flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle reference tick pulse |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, pending AND enable |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
Two pairs of events can land in the same clock cycle. In the first pair, a write that clears the status collides with the tick that sets the pending flag again. In the second pair, a keyed restart collides with the tick that would otherwise expire the count. The bench provokes each collision by using interval code 0, so that every tick is an expiring tick. It then raises the register write and the tick on the same falling edge. The result is judged afterwards at the ports: a status read returns 1 after the clear/expiry collision, and `irq` stays low after the restart/expiry collision until exactly one further tick has passed.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] OFF_IEN  = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_CFG  = 8'h14;
  localparam logic [7:0] OFF_MODE = 8'h18;

  localparam logic [11:0] RESTART_KEY = 12'hA57;

  localparam logic [1:0] ACT_SYSRST = 2'd1;
  localparam logic [1:0] ACT_IRQ    = 2'd2;

  localparam logic [3:0] DEF_INTV   = 4'd11;
  localparam int         RST_CYCLES = 4;
  localparam int         MAX_HALVES = 32;

  // Timeout in half-seconds for each interval code.
  function automatic logic [5:0] interval_halves(input logic [3:0] code);
    case (code)
      4'd0:    return 6'd1;
      4'd1:    return 6'd2;
      4'd2:    return 6'd4;
      4'd3:    return 6'd6;
      4'd4:    return 6'd8;
      4'd5:    return 6'd10;
      4'd6:    return 6'd12;
      4'd7:    return 6'd16;
      4'd8:    return 6'd20;
      4'd9:    return 6'd24;
      4'd10:   return 6'd28;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              expire,
  output logic [31:0]       rdata,
  output logic              irq_en,
  output logic              pend,
  output logic [1:0]        action,
  output logic              wd_en,
  output logic [3:0]        intv,
  output logic              restart,
  output logic              mode_chg
);
  logic sel_ien, sel_stat, sel_ctrl, sel_cfg, sel_mode;

  assign sel_ien  = we && (addr == ADDR_W'(OFF_IEN));
  assign sel_stat = we && (addr == ADDR_W'(OFF_STAT));
  assign sel_ctrl = we && (addr == ADDR_W'(OFF_CTRL));
  assign sel_cfg  = we && (addr == ADDR_W'(OFF_CFG));
  assign sel_mode = we && (addr == ADDR_W'(OFF_MODE));

  // R2: key and start bit must both match.
  assign restart = sel_ctrl && wdata[0] && (wdata[12:1] == RESTART_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      pend     <= 1'b0;
      action   <= ACT_SYSRST;
      wd_en    <= 1'b0;
      intv     <= DEF_INTV;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= sel_mode && ((wdata[0] != wd_en) || (wdata[7:4] != intv));
      if (sel_ien) irq_en <= wdata[0];
      if (sel_cfg) action <= wdata[1:0];
      if (sel_mode) begin
        wd_en <= wdata[0];
        intv  <= wdata[7:4];
      end
      // R8: a new expiry outranks a clearing write.
      if (expire && (action == ACT_IRQ)) pend <= 1'b1;
      else if (sel_stat && wdata[0])     pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_IEN):  rdata[0]   = irq_en;
      ADDR_W'(OFF_STAT): rdata[0]   = pend;
      ADDR_W'(OFF_CFG):  rdata[1:0] = action;
      ADDR_W'(OFF_MODE): begin
        rdata[0]   = wd_en;
        rdata[7:4] = intv;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int HALF_TICKS = 1,
  parameter int CNT_W      = $clog2(MAX_HALVES * HALF_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] intv,
  input  logic       reload,
  input  logic       tick,
  input  logic       hold,
  output logic       expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(interval_halves(intv)) * CNT_W'(HALF_TICKS);
  // R9: reload has priority over the final tick.
  assign expire = en && !reload && !hold && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!en || reload || expire)   cnt <= load_val;
    else if (tick && !hold)             cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/kwd_rstgen.sv
module kwd_rstgen
  import kwd_pkg::*;
#(
  parameter int LEN_W = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [LEN_W-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left <= '0;
    else if (fire)  left <= LEN_W'(RST_CYCLES);
    else if (pulse) left <= left - LEN_W'(1);
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int HALF_TICKS = 1,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              sys_rst
);
  logic       expire_w, irq_en_w, pend_w, wd_en_w, restart_w, mode_chg_w;
  logic [1:0] action_w;
  logic [3:0] intv_w;

  kwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .expire(expire_w), .rdata(rdata), .irq_en(irq_en_w), .pend(pend_w),
    .action(action_w), .wd_en(wd_en_w), .intv(intv_w),
    .restart(restart_w), .mode_chg(mode_chg_w)
  );

  kwd_counter #(.HALF_TICKS(HALF_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(wd_en_w), .intv(intv_w),
    .reload(restart_w || mode_chg_w), .tick(tick), .hold(sys_rst),
    .expire(expire_w)
  );

  kwd_rstgen u_rst (
    .clk(clk), .rst_n(rst_n),
    .fire(expire_w && (action_w == ACT_SYSRST)),
    .pulse(sys_rst)
  );

  assign irq = pend_w && irq_en_w;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              tick,
  input logic              sys_rst,
  input logic              expire,
  input logic              wd_en,
  input logic [1:0]        action,
  input logic              pend,
  input logic              restart
);
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ##1 sys_rst ##1 sys_rst ##1 sys_rst ##1 !sys_rst);

  a_r5_only_sysrst_action: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && action != ACT_SYSRST) |=> !$rose(sys_rst));

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !expire);

  a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && action == ACT_IRQ) |=> pend);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(OFF_STAT) && wdata[0] && !expire) |=> !pend);

  a_r9_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && tick) |-> !expire);
endmodule

bind keyed_watchdog kwd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .tick(tick), .sys_rst(sys_rst), .expire(expire_w), .wd_en(wd_en_w),
  .action(action_w), .pend(pend_w), .restart(restart_w)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  localparam logic [31:0] GOOD_KEY = 32'h0000_14AF;

  // {interval code, expected half-seconds}
  localparam logic [9:0] VEC [14] = '{
    {4'd0, 6'd1},  {4'd1, 6'd2},   {4'd2, 6'd4},   {4'd3, 6'd6},
    {4'd4, 6'd8},  {4'd5, 6'd10},  {4'd6, 6'd12},  {4'd7, 6'd16},
    {4'd8, 6'd20}, {4'd9, 6'd24},  {4'd10, 6'd28}, {4'd11, 6'd32},
    {4'd12, 6'd32}, {4'd15, 6'd32}
  };

  keyed_watchdog #(.HALF_TICKS(1), .ADDR_W(8)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R10 reset state
    rd(8'h00, v); chk("R10 ien", v, 0);
    rd(8'h04, v); chk("R10 stat", v, 0);
    rd(8'h10, v); chk("R1 ctrl", v, 0);
    rd(8'h14, v); chk("R10 cfg", v, 1);
    rd(8'h18, v); chk("R10 mode", v, 32'hB0);
    chk("R10 irq", {31'b0, irq}, 0);
    chk("R10 sys_rst", {31'b0, sys_rst}, 0);

    // R3 table walk in interrupt mode
    wr(8'h14, 2); wr(8'h00, 1);
    foreach (VEC[k]) begin
      wr(8'h18, {24'b0, VEC[k][9:6], 3'b0, 1'b1});
      wr(8'h04, 1);
      wr(8'h10, GOOD_KEY);
      ticks(int'(VEC[k][5:0]) - 1);
      chk($sformatf("R3 code %0d early", VEC[k][9:6]), {31'b0, irq}, 0);
      ticks(1);
      chk($sformatf("R3 code %0d expiry", VEC[k][9:6]), {31'b0, irq}, 1);
    end

    // R2 bad control words ignored (code 1 = 2 ticks)
    wr(8'h18, 32'h11); wr(8'h04, 1); wr(8'h10, GOOD_KEY);
    ticks(1);
    wr(8'h10, 32'h14AE); wr(8'h10, 32'h14AD);
    ticks(1);
    chk("R2 bad key ignored", {31'b0, irq}, 1);
    wr(8'h04, 1); wr(8'h10, GOOD_KEY);
    ticks(1); wr(8'h10, GOOD_KEY); ticks(1);
    chk("R2 good key restarts", {31'b0, irq}, 0);
    ticks(1);
    chk("R2 expiry after restart", {31'b0, irq}, 1);
    rd(8'h10, v); chk("R1 ctrl reads zero", v, 0);

    // R7 masking, R8 write-one-to-clear
    wr(8'h00, 0);
    chk("R7 masked irq", {31'b0, irq}, 0);
    rd(8'h04, v); chk("R7 pending visible", v, 1);
    wr(8'h00, 1);
    chk("R7 unmasked irq", {31'b0, irq}, 1);
    wr(8'h04, 0); rd(8'h04, v); chk("R8 write 0 no clear", v, 1);
    wr(8'h04, 1); rd(8'h04, v); chk("R8 write 1 clears", v, 0);

    // R8 collision: clear and expiry in one cycle (code 0)
    wr(8'h18, 32'h01); wr(8'h10, GOOD_KEY);
    ticks(1);
    @(negedge clk); we = 1'b1; addr = 8'h04; wdata = 1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(8'h04, v); chk("R8 set wins over clear", v, 1);

    // R9 collision: restart and expiring tick in one cycle
    wr(8'h04, 1);
    @(negedge clk); we = 1'b1; addr = 8'h10; wdata = GOOD_KEY; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    chk("R9 restart wins", {31'b0, irq}, 0);
    ticks(1);
    chk("R9 next tick expires", {31'b0, irq}, 1);

    // R5 reset action: 4-cycle pulse, no pending
    wr(8'h04, 1); wr(8'h14, 1); wr(8'h18, 32'h11); wr(8'h10, GOOD_KEY);
    ticks(2);
    chk("R5 pulse cycle 1", {31'b0, sys_rst}, 1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk); chk($sformatf("R5 pulse cycle %0d", i), {31'b0, sys_rst}, 1);
    end
    @(negedge clk); chk("R5 pulse ends", {31'b0, sys_rst}, 0);
    rd(8'h04, v); chk("R5 pending untouched", v, 0);

    // R6 action 3 does nothing
    wr(8'h14, 3); wr(8'h10, GOOD_KEY);
    ticks(2);
    chk("R6 action 3 no reset", {31'b0, sys_rst}, 0);
    rd(8'h04, v); chk("R6 action 3 no pending", v, 0);

    // R4 field readback, disable, re-enable reload
    wr(8'h18, 32'hFFFF_FF5F); rd(8'h18, v); chk("R4 mode readback", v, 32'h51);
    wr(8'h14, 2);
    wr(8'h18, 0); rd(8'h18, v); chk("R4 mode cleared", v, 0);
    ticks(40);
    rd(8'h04, v); chk("R4 disabled no expiry", v, 0);
    wr(8'h18, 32'h01);
    ticks(1);
    chk("R4 enable reloads and runs", {31'b0, irq}, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule